// File: doc/BRIEF.md
# Character Overlay Display Memory Write Controller

This block holds the character map of an on-screen text overlay and the register logic that fills it. A byte-oriented serial slave passes received bytes to it. While the select line is high, those bytes form header/payload pairs. The header names a register, and its top bit marks a read. The payload carries the value to write, or it is a dummy byte during which a read answer is shifted out. Each map entry is 16 bits wide: a character index in the low byte and an attribute byte in the high byte.

Software fills the map in one of two ways. It can place a single character at an explicit address. It can also open a streaming run, in which every payload stores a character, picks up the attribute held in the mode register, and moves the address forward by one. A payload of 0xFF ends the run without being stored. A clear command zeroes the whole map, one entry per clock. The command bit reads back as 1 until the clear has finished.

Top module: `osd_dispmem_ctrl`

## Requirements
- R1: While `sel` is high, the bytes marked by `byte_valid` alternate between header and payload, starting with a header. Header bit 7 = 1 means read; 0 means write. Header bits 6:0 select the register. Taking `sel` low returns the pairing to the header phase.
- R2: A read header causes the selected register value to appear on `resp_data`, with `resp_valid` high for exactly one cycle, on the clock edge that accepts the header. `resp_valid` is low at all other times.
- R3: The registers are: mode 0x04, address-high 0x05, address-low 0x06, data-in 0x07. Address-low holds address bits 7:0. Address-high bit 0 holds address bit 8 and bit 1 selects the attribute byte lane. Both read back, with address-high unused bits reading 0.
- R4: Mode bit 6 = 0 selects wide writes. A data-in write then stores the payload as the character and stores attribute byte {2'b00, mode[5:3], 3'b000}.
- R5: Mode bit 6 = 1 selects narrow writes. A data-in write then stores the payload only in the lane chosen by address-high bit 1, where 1 is the attribute lane and 0 is the character lane. The other lane keeps its value.
- R6: With mode bit 0 = 1, each stored data-in write advances the address by one. From 479 the address wraps to 0.
- R7: With mode bit 0 = 1, a data-in payload of 0xFF is not stored, leaves the address unchanged and clears mode bit 0.
- R8: With mode bit 0 = 0, a payload of 0xFF is stored like any other byte, and the address does not move.
- R9: At an address of 480 or above, a data-in write stores nothing and the address does not move. Data-out reads there return 0.
- R10: Writing mode with bit 2 = 1 starts a clear that zeroes all 480 entries over 480 cycles. Mode bit 2 and status bit 0 read 1 for exactly that time and then read 0 by themselves.
- R11: Data-in writes that arrive during a clear are ignored. They store nothing and do not move the address.
- R12: After reset, mode, address-high, address-low and status all read 0.
- R13: Status (index 0x20, header 0xA0) reads {6'b0, auto-increment, clear busy}. Data-out (index 0x30, header 0xB0) reads the selected lane of the addressed entry. Writes to these two registers, and to any register that is not defined, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Transfer window active (chip select, active high) |
| byte_valid | input | 1 | One received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| resp_valid | output | 1 | Read answer is valid this cycle |
| resp_data | output | 8 | Read answer byte |

## Verification
The bench targets the edge of the streaming run. At address 479, a design that saturated instead of wrapping would overwrite entry 479 a second time. If the 0xFF terminator were stored, or moved the address, it would corrupt the next entry. The same byte written outside streaming must land in memory, so a design that filtered 0xFF in every mode fails that test. A data-in write is sent in the middle of a clear; a design that let it through would leave a non-zero entry behind or shift the address. The bench also breaks a pair by dropping `sel` after a header, so a decoder that kept its phase would treat the next header as a payload.

// File: rtl/osd_dm_pkg.sv
package osd_dm_pkg;

  typedef logic [6:0] reg_idx_t;

  localparam reg_idx_t RI_MODE    = 7'h04;
  localparam reg_idx_t RI_ADDR_HI = 7'h05;
  localparam reg_idx_t RI_ADDR_LO = 7'h06;
  localparam reg_idx_t RI_DIN     = 7'h07;
  localparam reg_idx_t RI_STATUS  = 7'h20;
  localparam reg_idx_t RI_DOUT    = 7'h30;

  localparam logic [7:0] TERM_BYTE = 8'hFF;

  typedef struct packed {
    logic       narrow;
    logic [2:0] attr;
    logic       auto_en;
  } mode_t;

  // attribute byte stored with every wide write
  function automatic logic [7:0] attr_byte(input logic [2:0] a);
    return {2'b00, a, 3'b000};
  endfunction

  function automatic logic [7:0] mode_byte(input mode_t m, input logic busy);
    return {1'b0, m.narrow, m.attr, busy, 1'b0, m.auto_en};
  endfunction

endpackage

// File: rtl/osd_pair_decoder.sv
module osd_pair_decoder
  import osd_dm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       rd_stb,
  output reg_idx_t   rd_idx,
  output logic       wr_stb,
  output reg_idx_t   wr_idx,
  output logic [7:0] wr_data
);
  logic       payload_phase;
  logic [7:0] hdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payload_phase <= 1'b0;
      hdr_q         <= '0;
    end else if (!sel) begin
      payload_phase <= 1'b0;
    end else if (byte_valid) begin
      payload_phase <= !payload_phase;
      if (!payload_phase) hdr_q <= byte_data;
    end
  end

  always_comb begin
    rd_stb  = sel && byte_valid && !payload_phase && byte_data[7];
    rd_idx  = byte_data[6:0];
    wr_stb  = sel && byte_valid && payload_phase && !hdr_q[7];
    wr_idx  = hdr_q[6:0];
    wr_data = byte_data;
  end
endmodule

// File: rtl/osd_clear_seq.sv
module osd_clear_seq #(
  parameter int DEPTH = 480,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end
  end
endmodule

// File: rtl/osd_entry_mem.sv
module osd_entry_mem #(
  parameter int DEPTH = 480,
  parameter int AW    = $clog2(DEPTH),
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic [AW-1:0]      waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [8*LANES-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && be[g]) lane_mem[waddr] <= wdata[g*8 +: 8];
    end
    assign rdata[g*8 +: 8] = lane_mem[raddr];
  end
endmodule

// File: rtl/osd_dispmem_ctrl.sv
module osd_dispmem_ctrl
  import osd_dm_pkg::*;
#(
  parameter int DEPTH = 480,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       resp_valid,
  output logic [7:0] resp_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  logic          rd_stb, wr_stb;
  reg_idx_t      rd_idx, wr_idx;
  logic [7:0]    wr_data;
  mode_t         mode_q;
  logic [AW-1:0] addr_q;
  logic          lane_attr;
  logic          clr_active, clr_start;
  logic [AW-1:0] clr_idx;
  logic          din_wr, term_fire, store_fire, advance, in_range, auto_on;
  logic          mem_we;
  logic [1:0]    mem_be;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [15:0]   mem_wdata, mem_rdata;
  logic [7:0]    rd_mux;

  osd_pair_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_valid(byte_valid),
    .byte_data(byte_data), .rd_stb(rd_stb), .rd_idx(rd_idx),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  osd_clear_seq #(.DEPTH(DEPTH), .AW(AW)) u_clr (
    .clk(clk), .rst_n(rst_n), .start(clr_start),
    .active(clr_active), .idx(clr_idx)
  );

  osd_entry_mem #(.DEPTH(DEPTH), .AW(AW), .LANES(2)) u_mem (
    .clk(clk), .we(mem_we), .be(mem_be), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  always_comb begin
    auto_on    = mode_q.auto_en;
    in_range   = addr_q < AW'(DEPTH);
    din_wr     = wr_stb && (wr_idx == RI_DIN) && !clr_active;
    term_fire  = din_wr && auto_on && (wr_data == TERM_BYTE);
    store_fire = din_wr && !term_fire && in_range;
    advance    = store_fire && auto_on;
    clr_start  = wr_stb && (wr_idx == RI_MODE) && wr_data[2] && !clr_active;

    mem_we    = clr_active || store_fire;
    mem_waddr = clr_active ? clr_idx : addr_q;
    mem_raddr = in_range ? addr_q : '0;
    if (clr_active) begin
      mem_be    = 2'b11;
      mem_wdata = '0;
    end else if (mode_q.narrow) begin
      mem_be    = lane_attr ? 2'b10 : 2'b01;
      mem_wdata = {wr_data, wr_data};
    end else begin
      mem_be    = 2'b11;
      mem_wdata = {attr_byte(mode_q.attr), wr_data};
    end

    unique case (rd_idx)
      RI_MODE:    rd_mux = mode_byte(mode_q, clr_active);
      RI_ADDR_HI: rd_mux = {6'b0, lane_attr, addr_q[AW-1]};
      RI_ADDR_LO: rd_mux = addr_q[7:0];
      RI_STATUS:  rd_mux = {6'b0, auto_on, clr_active};
      RI_DOUT:    rd_mux = !in_range ? 8'h00 :
                           (lane_attr ? mem_rdata[15:8] : mem_rdata[7:0]);
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      addr_q    <= '0;
      lane_attr <= 1'b0;
    end else begin
      if (wr_stb) begin
        case (wr_idx)
          RI_MODE:    mode_q <= '{narrow: wr_data[6], attr: wr_data[5:3],
                                  auto_en: wr_data[0]};
          RI_ADDR_HI: begin
            lane_attr      <= wr_data[1];
            addr_q[AW-1]   <= wr_data[0];
          end
          RI_ADDR_LO: addr_q[7:0] <= wr_data;
          default: ;
        endcase
      end
      if (term_fire) mode_q.auto_en <= 1'b0;
      if (advance)   addr_q <= step_addr(addr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= rd_stb;
      if (rd_stb) resp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/osd_dispmem_checker.sv
module osd_dispmem_checker #(
  parameter int DEPTH = 480,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic          resp_valid,
  input logic          store_fire,
  input logic          term_fire,
  input logic          auto_on,
  input logic [AW-1:0] addr_q,
  input logic          clr_start,
  input logic          clr_active,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [15:0]   mem_wdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (clr_active) busy_cnt <= busy_cnt + 1'b1;
    else                 busy_cnt <= '0;
  end

  assert_resp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> resp_valid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !resp_valid);
  assert_stream_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && auto_on && addr_q != LAST) |=> addr_q == $past(addr_q) + 1'b1);
  assert_stream_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && auto_on && addr_q == LAST) |=> addr_q == '0);
  assert_term_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    term_fire |=> (!auto_on && addr_q == $past(addr_q)));
  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_waddr < AW'(DEPTH));
  assert_clear_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start |=> clr_active);
  assert_clear_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_active) |-> busy_cnt == CW'(DEPTH));
  assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> (mem_we && mem_wdata == 16'h0000));
endmodule

bind osd_dispmem_ctrl osd_dispmem_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .resp_valid(resp_valid),
  .store_fire(store_fire), .term_fire(term_fire), .auto_on(auto_on),
  .addr_q(addr_q), .clr_start(clr_start), .clr_active(clr_active),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
);

// File: tb/osd_dispmem_ctrl_test.sv
`timescale 1ns/1ps
module osd_dispmem_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       resp_valid;
  logic [7:0] resp_data;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] got;

  always #4 clk = !clk;

  osd_dispmem_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_valid(byte_valid),
    .byte_data(byte_data), .resp_valid(resp_valid), .resp_data(resp_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic wr(input logic [6:0] idx, input logic [7:0] d);
    send_byte({1'b0, idx}); send_byte(d);
  endtask

  // R2: answer is sampled one cycle after the header edge
  task automatic rd(input logic [6:0] idx, output logic [7:0] v);
    send_byte({1'b1, idx});
    check("R2 resp_valid", int'(resp_valid), 1);
    v = resp_data;
    send_byte(8'h00);
    check("R2 resp_valid drop", int'(resp_valid), 0);
  endtask

  task automatic set_addr(input int a, input bit lane);
    wr(7'h05, {6'b0, lane, a[8]}); wr(7'h06, a[7:0]);
  endtask

  task automatic entry(input int a, input bit lane, output logic [7:0] v);
    set_addr(a, lane); rd(7'h30, v);
  endtask

  task automatic t_reset;
    check("R12 resp_valid idle", int'(resp_valid), 0);
    rd(7'h04, got); check("R12 mode", got, 8'h00);
    rd(7'h05, got); check("R12 addr hi", got, 8'h00);
    rd(7'h06, got); check("R12 addr lo", got, 8'h00);
    rd(7'h20, got); check("R12 status", got, 8'h00);
  endtask

  task automatic t_addr_regs;
    wr(7'h05, 8'hFF); wr(7'h06, 8'h2A);
    rd(7'h05, got); check("R3 addr hi", got, 8'h03);
    rd(7'h06, got); check("R3 addr lo", got, 8'h2A);
  endtask

  task automatic t_wide;
    wr(7'h04, 8'h28);
    set_addr(5, 0); wr(7'h07, 8'h41);
    rd(7'h06, got); check("R4 no advance", got, 8'd5);
    entry(5, 0, got); check("R4 char", got, 8'h41);
    entry(5, 1, got); check("R4 attr", got, 8'h28);
  endtask

  task automatic t_narrow;
    wr(7'h04, 8'h00); set_addr(6, 0); wr(7'h07, 8'h11);
    wr(7'h04, 8'h40); set_addr(6, 1); wr(7'h07, 8'h5A);
    entry(6, 0, got); check("R5 char kept", got, 8'h11);
    entry(6, 1, got); check("R5 attr lane", got, 8'h5A);
    wr(7'h04, 8'h00);
  endtask

  task automatic t_stream;
    set_addr(10, 0); wr(7'h04, 8'h19);
    wr(7'h07, 8'h01); wr(7'h07, 8'h02); wr(7'h07, 8'h03);
    rd(7'h06, got); check("R6 addr after 3", got, 8'd13);
    rd(7'h04, got); check("R6 mode kept", got, 8'h19);
    for (int i = 0; i < 3; i++) begin
      entry(10 + i, 0, got); check("R6 char", got, i + 1);
      entry(10 + i, 1, got); check("R4 stream attr", got, 8'h18);
    end
    wr(7'h04, 8'h00);
  endtask

  task automatic t_wrap;
    set_addr(479, 0); wr(7'h04, 8'h01);
    wr(7'h07, 8'h77); wr(7'h07, 8'h78);
    rd(7'h05, got); check("R6 wrap hi", got, 8'h00);
    rd(7'h06, got); check("R6 wrap lo", got, 8'h01);
    wr(7'h04, 8'h00);
    entry(479, 0, got); check("R6 last entry", got, 8'h77);
    entry(0, 0, got);   check("R6 wrapped entry", got, 8'h78);
  endtask

  task automatic t_term;
    set_addr(21, 0); wr(7'h07, 8'h99);
    set_addr(20, 0); wr(7'h04, 8'h01);
    wr(7'h07, 8'h30); wr(7'h07, 8'hFF);
    rd(7'h06, got); check("R7 addr held", got, 8'd21);
    rd(7'h04, got); check("R7 auto cleared", got, 8'h00);
    rd(7'h30, got); check("R7 not stored", got, 8'h99);
    wr(7'h07, 8'h31);
    rd(7'h30, got); check("R7 single after run", got, 8'h31);
    rd(7'h06, got); check("R7 no advance after run", got, 8'd21);
  endtask

  task automatic t_ff_single;
    set_addr(30, 0); wr(7'h07, 8'hFF);
    entry(30, 0, got); check("R8 0xFF stored", got, 8'hFF);
    rd(7'h06, got); check("R8 addr held", got, 8'd30);
  endtask

  task automatic t_range;
    set_addr(500, 0); wr(7'h04, 8'h01); wr(7'h07, 8'h12);
    rd(7'h06, got); check("R9 addr held", got, 8'hF4);
    rd(7'h05, got); check("R9 addr hi", got, 8'h01);
    rd(7'h30, got); check("R9 dout zero", got, 8'h00);
    wr(7'h04, 8'h00);
    entry(479, 0, got); check("R9 last untouched", got, 8'h77);
    entry(0, 0, got);   check("R9 first untouched", got, 8'h78);
  endtask

  task automatic t_unknown;
    set_addr(50, 0); wr(7'h07, 8'h44);
    wr(7'h30, 8'h99); wr(7'h20, 8'h99); wr(7'h0F, 8'h99);
    rd(7'h04, got); check("R13 mode unchanged", got, 8'h00);
    rd(7'h20, got); check("R13 status unchanged", got, 8'h00);
    rd(7'h30, got); check("R13 entry unchanged", got, 8'h44);
    rd(7'h06, got); check("R13 addr unchanged", got, 8'd50);
  endtask

  task automatic t_clear;
    set_addr(40, 0); wr(7'h07, 8'h55);
    wr(7'h04, 8'h05);
    rd(7'h20, got); check("R10 status busy", got, 8'h03);
    rd(7'h04, got); check("R10 mode bit2 set", got, 8'h05);
    wr(7'h07, 8'h66);
    rd(7'h06, got); check("R11 addr held", got, 8'd40);
    repeat (600) @(negedge clk);
    rd(7'h20, got); check("R10 status done", got, 8'h02);
    rd(7'h04, got); check("R10 bit2 dropped", got, 8'h01);
    wr(7'h04, 8'h00);
    entry(40, 0, got);  check("R11 entry cleared", got, 8'h00);
    entry(40, 1, got);  check("R10 attr cleared", got, 8'h00);
    entry(479, 0, got); check("R10 last cleared", got, 8'h00);
    entry(5, 1, got);   check("R10 attr 5 cleared", got, 8'h00);
  endtask

  task automatic t_frame;
    wr(7'h06, 8'h11);
    send_byte(8'h06);
    @(negedge clk); sel = 1'b0;
    @(negedge clk); sel = 1'b1;
    send_byte(8'h86);
    check("R1 header after reframe", int'(resp_valid), 1);
    check("R1 addr lo read", resp_data, 8'h11);
    send_byte(8'h00);
    rd(7'h06, got); check("R1 addr lo intact", got, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; sel = 1'b1;
    @(negedge clk);
    t_reset; t_addr_regs; t_wide; t_narrow; t_stream; t_wrap;
    t_term; t_ff_single; t_range; t_unknown; t_clear; t_frame;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule